// File: doc/BRIEF.md
# Half-duplex line driver-enable sequencer

This block drives the enable pin of an external half-duplex line transceiver around the characters a serial transmitter sends. When a character is waiting, it turns the driver on. It then waits a programmable number of oversampling ticks before it tells the transmitter to begin the start bit. After the transmitter reports the end of a stop bit, the driver stays on for a second programmable number of ticks before it is released. Both times are 5-bit counts of sample-time units, which are 1/8 or 1/16 of a bit depending on the oversampling rate. The bit-rate logic supplies these units as a one-cycle `tick_i` pulse.

If a new character is queued while the release countdown is running, or at the moment the stop bit ends, the driver stays on. The next character starts with no lead delay, and the release countdown starts again after that character's stop bit. A mode bit turns the whole feature off. With the mode off, characters start at once and the enable pin stays at its inactive level. A polarity input selects whether the enable pin is active high or active low.

Top module: `txen_seq`

## Requirements
- R1: With `mode_en_i` low when a burst starts, `drv_en_o` stays at its inactive level for the whole burst, and `go_o` pulses in the cycle after `req_i` is sampled high in idle.
- R2: With the mode on and `lead_i` = N > 0, `drv_en_o` becomes active in the cycle after `req_i` is sampled high in idle. `go_o` pulses in the cycle after the Nth `tick_i` sampled from then on. Cycles without a tick do not count.
- R3: With the mode on and `lead_i` = 0, `drv_en_o` becomes active and `go_o` pulses in the same cycle, the one after `req_i` is sampled.
- R4: With the mode on and `lag_i` = M > 0, once `done_i` is sampled with no character queued, `drv_en_o` stays active until the Mth following `tick_i` is sampled. It turns inactive in the next cycle.
- R5: With `lag_i` = 0, `drv_en_o` turns inactive in the cycle after `done_i` is sampled with no character queued.
- R6: A `req_i` sampled together with `done_i`, or during the release countdown, gives a `go_o` pulse in the next cycle with no lead delay. `drv_en_o` stays active, and the full release countdown restarts after the next `done_i`.
- R7: `active_low_i` = 1 inverts the pin, so that active is 0 and inactive is 1. The pin follows `active_low_i` in the same cycle.
- R8: `go_o` is a one-cycle pulse. While a character is being sent, `req_i` and `tick_i` have no effect until `done_i` arrives.
- R9: After reset, `go_o` is 0 and `drv_en_o` is at its inactive level.
- R10: `mode_en_i` is sampled only when a burst starts from idle. A change to it during a burst takes effect at the next burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse per sample-time unit |
| mode_en_i | input | 1 | Driver-enable sequencing on |
| active_low_i | input | 1 | 1: enable pin active low |
| lead_i | input | 5 | Ticks from enable to start bit |
| lag_i | input | 5 | Ticks from end of stop bit to release |
| req_i | input | 1 | A character is queued |
| done_i | input | 1 | Pulse from transmitter: stop bit ended |
| go_o | output | 1 | Pulse to transmitter: begin start bit |
| drv_en_o | output | 1 | Transceiver driver-enable pin |

## Verification
`go_o` and the enable pin are both registered outputs. They change one cycle after the edge that samples `req_i`, `done_i` or the final `tick_i`. The only exception is polarity, which acts through logic on the output. The bench drives inputs 1 ns after a rising edge and reads the outputs at that moment, after one more edge, so each check falls in the first cycle in which the result is due. Tick pulses are separated by cycles without a tick. This shows that the delays count ticks and not clock cycles.

// File: rtl/txen_pkg.sv
package txen_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LEAD = 2'd1,
    ST_SEND = 2'd2,
    ST_LAG  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/txen_tick_cnt.sv
module txen_tick_cnt #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (load_i)                    cnt_q <= val_i;
    else if (dec_i && cnt_q != '0)      cnt_q <= cnt_q - ONE;
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == ONE);
endmodule

// File: rtl/txen_fsm.sv
module txen_fsm
  import txen_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             mode_en_i,
  input  logic [CNT_W-1:0] lead_i,
  input  logic [CNT_W-1:0] lag_i,
  input  logic             req_i,
  input  logic             done_i,
  input  logic             last_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             load_o,
  output logic [CNT_W-1:0] val_o,
  output logic             dec_o,
  output logic             go_o,
  output logic             de_o
);
  seq_state_e st_q, st_d;
  logic go_q, go_d, de_q, de_d, en_q, en_d;

  always_comb begin
    st_d   = st_q;
    go_d   = 1'b0;
    de_d   = de_q;
    en_d   = en_q;
    load_o = 1'b0;
    val_o  = '0;
    unique case (st_q)
      ST_IDLE: if (req_i) begin
        en_d = mode_en_i;  // burst-wide mode latch
        if (mode_en_i && lead_i != '0) begin
          st_d   = ST_LEAD;
          de_d   = 1'b1;
          load_o = 1'b1;
          val_o  = lead_i;
        end else begin
          st_d = ST_SEND;
          go_d = 1'b1;
          de_d = mode_en_i;
        end
      end
      ST_LEAD: if (tick_i && last_i) begin
        st_d = ST_SEND;
        go_d = 1'b1;
      end
      ST_SEND: if (done_i) begin
        if (req_i) begin
          go_d = 1'b1;
        end else if (en_q && lag_i != '0) begin
          st_d   = ST_LAG;
          load_o = 1'b1;
          val_o  = lag_i;
        end else begin
          st_d = ST_IDLE;
          de_d = 1'b0;
        end
      end
      ST_LAG: begin
        if (req_i) begin
          st_d = ST_SEND;
          go_d = 1'b1;
        end else if (tick_i && last_i) begin
          st_d = ST_IDLE;
          de_d = 1'b0;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign dec_o = tick_i && (st_q == ST_LEAD || (st_q == ST_LAG && !req_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      go_q <= 1'b0;
      de_q <= 1'b0;
      en_q <= 1'b0;
    end else begin
      st_q <= st_d;
      go_q <= go_d;
      de_q <= de_d;
      en_q <= en_d;
    end
  end

  assign go_o = go_q;
  assign de_o = de_q;

  AST_GO_DE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_q |-> (de_q == en_q)); // R1
  AST_LEAD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LEAD && !(tick_i && last_i)) |=> (st_q == ST_LEAD && !go_q)); // R2
  AST_WAIT_CNT_NZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LEAD || st_q == ST_LAG) |-> (cnt_i != '0)); // R4
  AST_DE_FALL_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(de_q) |-> ($past(st_q) == ST_LAG || $past(done_i))); // R5
  AST_SEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SEND && !done_i) |=> (st_q == ST_SEND && !go_q)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |-> (!de_q && !go_q)); // R9
endmodule

// File: rtl/txen_pol.sv
module txen_pol (
  input  logic de_i,
  input  logic active_low_i,
  output logic drv_en_o
);
  assign drv_en_o = de_i ^ active_low_i;
endmodule

// File: rtl/txen_seq.sv
module txen_seq #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             mode_en_i,
  input  logic             active_low_i,
  input  logic [CNT_W-1:0] lead_i,
  input  logic [CNT_W-1:0] lag_i,
  input  logic             req_i,
  input  logic             done_i,
  output logic             go_o,
  output logic             drv_en_o
);
  logic             load, dec, last, de;
  logic [CNT_W-1:0] val, cnt;

  txen_tick_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .val_i(val),
    .dec_i(dec), .cnt_o(cnt), .last_o(last)
  );

  txen_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .mode_en_i(mode_en_i),
    .lead_i(lead_i), .lag_i(lag_i), .req_i(req_i), .done_i(done_i),
    .last_i(last), .cnt_i(cnt), .load_o(load), .val_o(val), .dec_o(dec),
    .go_o(go_o), .de_o(de)
  );

  txen_pol u_pol (.de_i(de), .active_low_i(active_low_i), .drv_en_o(drv_en_o));

  AST_POL_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_o && !de) |-> (drv_en_o == active_low_i)); // R7
endmodule

// File: tb/txen_seq_bench.sv
module txen_seq_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, mode_en = 0, act_lo = 0, req = 0, done = 0;
  logic [4:0] lead = 0, lag = 0;
  logic go, drv;
  int checks = 0, fails = 0;
  bit fin = 0;

  always #2.5 clk = ~clk;

  txen_seq u_txen_seq (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .mode_en_i(mode_en),
    .active_low_i(act_lo), .lead_i(lead), .lag_i(lag), .req_i(req),
    .done_i(done), .go_o(go), .drv_en_o(drv)
  );

  // row: {mode_en, active_low, lead[4:0], lag[4:0]}
  localparam logic [11:0] VEC [8] = '{
    {1'b0, 1'b0, 5'd5,  5'd3},
    {1'b1, 1'b0, 5'd3,  5'd2},
    {1'b1, 1'b0, 5'd0,  5'd0},
    {1'b1, 1'b1, 5'd0,  5'd4},
    {1'b1, 1'b0, 5'd31, 5'd31},
    {1'b1, 1'b1, 5'd1,  5'd1},
    {1'b0, 1'b1, 5'd2,  5'd2},
    {1'b1, 1'b1, 5'd2,  5'd0}
  };

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic lvl(input logic active);
    return active ^ act_lo;
  endfunction

  task automatic tick_step();
    step();            // a cycle with no tick must not count
    tick = 1; step(); tick = 0;
  endtask

  task automatic run_row(input logic [11:0] row);
    logic en;
    logic [4:0] ld, lg;
    en = row[11]; act_lo = row[10]; ld = row[9:5]; lg = row[4:0];
    mode_en = en; lead = ld; lag = lg;
    step();
    chk(drv, lvl(1'b0), "R7 idle level");
    req = 1; step(); req = 0;
    chk(drv, lvl(en), en ? "R2 enable on request" : "R1 pin stays inactive");
    if (!en || ld == 0) chk(go, 1'b1, en ? "R3 zero lead go" : "R1 immediate go");
    else begin
      chk(go, 1'b0, "R2 no early go");
      for (int i = 1; i <= int'(ld); i++) begin
        tick_step();
        chk(go, (i == int'(ld)), "R2 go after lead ticks");
        chk(drv, lvl(1'b1), "R2 enable held in lead");
      end
    end
    tick = 1; step(); tick = 0;
    chk(go, 1'b0, "R8 single go pulse");
    chk(drv, lvl(en), "R8 tick while sending");
    done = 1; step(); done = 0;
    if (!en || lg == 0) chk(drv, lvl(1'b0), en ? "R5 zero lag release" : "R1 inactive after done");
    else begin
      chk(drv, lvl(1'b1), "R4 held after done");
      for (int i = 1; i <= int'(lg); i++) begin
        tick_step();
        chk(drv, lvl(i < int'(lg)), "R4 release after lag ticks");
      end
    end
    step();
    chk(go, 1'b0, "R8 no go when idle");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    step();
    chk(go, 1'b0, "R9 reset go");
    chk(drv, 1'b0, "R9 reset pin");
    act_lo = 1; #1;
    chk(drv, 1'b1, "R7 polarity flips pin at once");
    act_lo = 0; #1;

    for (int r = 0; r < 8; r++) run_row(VEC[r]);

    // R6: queued during release countdown, then req at done
    act_lo = 0; mode_en = 1; lead = 5'd2; lag = 5'd3;
    req = 1; step(); req = 0;
    tick_step(); tick_step();
    chk(go, 1'b1, "R6 setup go");
    done = 1; step(); done = 0;
    tick_step();
    req = 1; step(); req = 0;
    chk(go, 1'b1, "R6 go without lead delay");
    chk(drv, 1'b1, "R6 pin stays active");
    req = 1;
    for (int i = 0; i < 3; i++) begin
      tick = 1; step(); tick = 0;
      chk(go, 1'b0, "R8 held req ignored while sending");
    end
    done = 1; step(); done = 0; req = 0;
    chk(go, 1'b1, "R6 req at done starts next char");
    chk(drv, 1'b1, "R6 pin active at back-to-back");
    done = 1; step(); done = 0;
    tick_step(); tick_step();
    chk(drv, 1'b1, "R6 countdown restarted");
    tick_step();
    chk(drv, 1'b0, "R6 release after full lag");

    // R10: mode change during a burst
    lead = 5'd0; lag = 5'd0;
    req = 1; step(); req = 0;
    mode_en = 0; step();
    chk(drv, 1'b1, "R10 mode drop mid-burst ignored");
    done = 1; step(); done = 0;
    chk(drv, 1'b0, "R10 release at done");
    req = 1; step(); req = 0;
    chk(drv, 1'b0, "R10 next burst uses new mode");
    chk(go, 1'b1, "R10 immediate go");
    done = 1; step(); done = 0;

    fin = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule